// File: doc/BRIEF.md
# Register-Pair Immediate Word Adder

This block carries out the add-immediate-to-word operation of an 8-bit processor core. An accepted instruction names one of four 16-bit register pairs at the top of a 32-entry byte-wide register file and a 6-bit unsigned constant. The block adds the constant to the pair and writes the wrapped 16-bit sum back. It then updates the status byte with zero, negative, overflow, sign and carry flags computed from bit 15 of the old and new values.

The register file is reached through one asynchronous byte read port and one byte write port. The word is handled as a little-endian pair: the low byte sits in the even register, the high byte in the next odd register. The low byte is processed in the first cycle and the high byte in the second, and the carry between the two halves is held in a flop. The instruction input is a valid/ready stream. A transfer happens on a rising edge where both `insn_valid` and `insn_ready` are high. `insn_ready` stays low from the cycle after an accepted operation until the cycle after its done pulse. While it is low, the source must keep or withdraw its request, and nothing it presents is taken.

Top module: `regpair_imm_adder`

## Requirements
- R1: After reset, `insn_ready` is 1 and `busy`, `done`, `rf_wr_en` and `sreg_wr_en` are 0.
- R2: An instruction is taken when `insn_valid` and `insn_ready` are both high at a rising edge. It starts an operation only if `insn[15:8]` equals 8'h96. Any other taken word causes no register write and no status write, and `busy` stays 0.
- R3: The pair's low byte is register 24 + 2*`insn[5:4]` (one of 24, 26, 28 or 30), and its high byte is that register plus one.
- R4: The constant is `{insn[7:6], insn[3:0]}`, zero-extended. The pair's new value is (old value + constant) mod 65536.
- R5: In the first cycle after acceptance, the low byte is read and written. In the second cycle, the high byte is read and written. No other register is written.
- R6: `busy` is high and `insn_ready` is low from the first cycle after acceptance through the done cycle. An instruction presented in that time is not taken.
- R7: `done` is high for exactly one cycle, the cycle right after the high-byte write.
- R8: The status byte is written with `sreg_wr_en` during the high-byte cycle. Bit 1 (Z) is set when the 16-bit result is zero, and bit 2 (N) equals result bit 15.
- R9: Bit 3 (V) = !old[15] & new[15]. Bit 0 (C) = old[15] & !new[15]. Bit 4 (S) = N ^ V.
- R10: Status bits 7:5 of `sreg_out` equal those of `sreg_in` when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is presented |
| insn | input | 16 | Instruction word |
| insn_ready | output | 1 | Block can take an instruction |
| busy | output | 1 | Operation in progress, including done cycle |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_addr | output | 5 | Register file read address |
| rf_rd_data | input | 8 | Register file read data (same cycle) |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 5 | Register file write address |
| rf_wr_data | output | 8 | Register file write data |
| sreg_in | input | 8 | Current status byte |
| sreg_wr_en | output | 1 | Status byte write enable |
| sreg_out | output | 8 | New status byte |

## Verification
Several internal faults show up at the ports within a few cycles. A wrong held carry or low-zero flop corrupts the high byte written in the second cycle or the Z bit in the same cycle. A wrong phase register shows as a misordered write address, a `done` pulse that lands early or late, or a second instruction taken while busy. The vectors are chosen to cross each flag boundary: carry and zero together from wrapping, overflow into bit 15, a negative result with no change, and a carry ripple out of the low byte.

// File: rtl/pairimm_pkg.sv
package pairimm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_FIN  = 2'd3
  } phase_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
endpackage

// File: rtl/pairimm_decode.sv
module pairimm_decode #(
  parameter int INSN_W    = 16,
  parameter int REG_AW    = 5,
  parameter int IMM_W     = 6,
  parameter int PAIR_BASE = 24,
  parameter logic [7:0] OPC_HI = 8'h96
) (
  input  logic [INSN_W-1:0] insn,
  output logic              hit,
  output logic [REG_AW-1:0] base_addr,
  output logic [IMM_W-1:0]  imm
);
  logic [1:0] sel;

  assign hit       = (insn[15:8] == OPC_HI);
  assign sel       = insn[5:4];
  assign base_addr = REG_AW'(PAIR_BASE) + REG_AW'({sel, 1'b0});
  assign imm       = {insn[7:6], insn[3:0]};
endmodule

// File: rtl/pairimm_byte_add.sv
module pairimm_byte_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;

  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/pairimm_flags.sv
module pairimm_flags
  import pairimm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [7:0]   sreg_in,
  input  logic         old_msb,
  input  logic [W-1:0] hi_sum,
  input  logic         lo_zero,
  output logic [7:0]   sreg_out
);
  logic z, n, v, c;

  assign n = hi_sum[W-1];
  assign z = lo_zero && (hi_sum == '0);
  assign v = !old_msb && n;
  assign c = old_msb && !n;

  always_comb begin
    sreg_out         = sreg_in;
    sreg_out[FLAG_C] = c;
    sreg_out[FLAG_Z] = z;
    sreg_out[FLAG_N] = n;
    sreg_out[FLAG_V] = v;
    sreg_out[FLAG_S] = n ^ v;
  end
endmodule

// File: rtl/regpair_imm_adder.sv
module regpair_imm_adder
  import pairimm_pkg::*;
#(
  parameter int INSN_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 32,
  parameter int IMM_W     = 6,
  parameter int PAIR_BASE = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        insn_valid,
  input  logic [INSN_W-1:0]           insn,
  output logic                        insn_ready,
  output logic                        busy,
  output logic                        done,
  output logic [$clog2(NUM_REGS)-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0]           rf_rd_data,
  output logic                        rf_wr_en,
  output logic [$clog2(NUM_REGS)-1:0] rf_wr_addr,
  output logic [DATA_W-1:0]           rf_wr_data,
  input  logic [7:0]                  sreg_in,
  output logic                        sreg_wr_en,
  output logic [7:0]                  sreg_out
);
  localparam int REG_AW = $clog2(NUM_REGS);

  phase_t              phase_q;
  logic [REG_AW-1:0]   base_q;
  logic [IMM_W-1:0]    imm_q;
  logic                carry_q;
  logic                lo_zero_q;

  logic                dec_hit;
  logic [REG_AW-1:0]   dec_base;
  logic [IMM_W-1:0]    dec_imm;
  logic                take;

  logic [DATA_W-1:0]   add_b;
  logic                add_cin;
  logic [DATA_W-1:0]   add_sum;
  logic                add_cout;
  logic                in_lo, in_hi;

  pairimm_decode #(
    .INSN_W(INSN_W), .REG_AW(REG_AW), .IMM_W(IMM_W), .PAIR_BASE(PAIR_BASE)
  ) u_dec (
    .insn(insn), .hit(dec_hit), .base_addr(dec_base), .imm(dec_imm)
  );

  assign insn_ready = (phase_q == PH_IDLE);
  assign take       = insn_valid && insn_ready && dec_hit;
  assign in_lo      = (phase_q == PH_LO);
  assign in_hi      = (phase_q == PH_HI);

  assign add_b   = in_lo ? DATA_W'(imm_q) : '0;
  assign add_cin = in_hi ? carry_q : 1'b0;

  pairimm_byte_add #(.W(DATA_W)) u_add (
    .a(rf_rd_data), .b(add_b), .cin(add_cin), .sum(add_sum), .cout(add_cout)
  );

  pairimm_flags #(.W(DATA_W)) u_flags (
    .sreg_in(sreg_in), .old_msb(rf_rd_data[DATA_W-1]), .hi_sum(add_sum),
    .lo_zero(lo_zero_q), .sreg_out(sreg_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      base_q    <= '0;
      imm_q     <= '0;
      carry_q   <= 1'b0;
      lo_zero_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= in_hi;
      unique case (phase_q)
        PH_IDLE: if (take) begin
          phase_q <= PH_LO;
          base_q  <= dec_base;
          imm_q   <= dec_imm;
        end
        PH_LO: begin
          carry_q   <= add_cout;
          lo_zero_q <= (add_sum == '0);
          phase_q   <= PH_HI;
        end
        PH_HI:   phase_q <= PH_FIN;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign rf_rd_addr = in_hi ? (base_q | REG_AW'(1)) : base_q;
  assign rf_wr_addr = rf_rd_addr;
  assign rf_wr_en   = in_lo || in_hi;
  assign rf_wr_data = add_sum;
  assign sreg_wr_en = in_hi;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> insn_ready && !busy && !done) // R1
    else $error("reset state wrong");
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rf_wr_en |-> busy && !insn_ready) // R5
    else $error("write outside operation");
  AST_HI_WRITE_ODD: assert property (@(posedge clk) disable iff (!rst_n) sreg_wr_en |-> rf_wr_en && rf_wr_addr[0]) // R8
    else $error("status write not with high byte");
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n) sreg_wr_en |-> $past(rf_wr_en) && !$past(rf_wr_addr[0])) // R5
    else $error("high byte not preceded by low byte");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) // R7
    else $error("done longer than one cycle");
  AST_DONE_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(sreg_wr_en)) // R7
    else $error("done without high write");
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !insn_ready) // R6
    else $error("ready while busy");
  AST_VC_EXCL: assert property (@(posedge clk) disable iff (!rst_n) sreg_wr_en |-> !(sreg_out[3] && sreg_out[0])) // R9
    else $error("V and C both set");
  AST_HIGH_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) sreg_wr_en |-> sreg_out[7:5] == sreg_in[7:5]) // R10
    else $error("status upper bits altered");
endmodule

// File: tb/regpair_imm_adder_tb.sv
module regpair_imm_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = 16'h0000;
  logic        insn_ready, busy, done;
  logic [4:0]  rf_rd_addr, rf_wr_addr;
  logic [7:0]  rf_rd_data, rf_wr_data;
  logic        rf_wr_en, sreg_wr_en;
  logic [7:0]  sreg_in = 8'h00;
  logic [7:0]  sreg_out;

  logic [7:0]  regs [32];
  int          n_tests = 0;
  int          n_fail = 0;
  int          wr_n = 0;
  int          sw_n = 0;
  int          done_n = 0;
  logic [4:0]  wr_log [4];
  logic [7:0]  sreg_cap;

  // fields: insn, old pair, sreg_in, expected pair, expected sreg
  localparam logic [63:0] VEC [6] = '{
    {16'h9601, 16'h00FF, 8'h00, 16'h0100, 8'h00},
    {16'h96FF, 16'hFFFF, 8'hE0, 16'h003E, 8'hE1},
    {16'h9610, 16'h8000, 8'h1F, 16'h8000, 8'h14},
    {16'h96E1, 16'h7FF0, 8'h40, 16'h8021, 8'h4C},
    {16'h9602, 16'hFFFE, 8'hA0, 16'h0000, 8'hA3},
    {16'h963F, 16'h1234, 8'hFF, 16'h1243, 8'hE0}
  };

  always #10 clk = ~clk;

  regpair_imm_adder dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .insn_ready(insn_ready), .busy(busy), .done(done),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .sreg_in(sreg_in), .sreg_wr_en(sreg_wr_en), .sreg_out(sreg_out)
  );

  assign rf_rd_data = regs[rf_rd_addr];

  always @(posedge clk) if (rf_wr_en) regs[rf_wr_addr] <= rf_wr_data;

  always @(negedge clk) begin
    if (rf_wr_en) begin
      if (wr_n < 4) wr_log[wr_n] = rf_wr_addr;
      wr_n = wr_n + 1;
    end
    if (sreg_wr_en) begin
      sreg_cap = sreg_out;
      sw_n = sw_n + 1;
    end
    if (done) done_n = done_n + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_pairs();
    for (int i = 24; i < 32; i++) regs[i] = 8'h5A;
  endtask

  // issue one instruction; returns negedges from drive to first done
  task automatic issue(input logic [15:0] w, output int lat);
    @(negedge clk);
    #1;
    wr_n = 0; sw_n = 0; done_n = 0; lat = 0;
    insn_valid = 1'b1; insn = w;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      #1;
      if (k == 1) insn_valid = 1'b0;
      if (done && lat == 0) lat = k;
    end
  endtask

  initial begin
    int lat;
    for (int i = 0; i < 32; i++) regs[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(insn_ready), 32'd1);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 writes", 32'({rf_wr_en, sreg_wr_en}), 32'd0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      logic [15:0] w, oldp, expp;
      logic [7:0]  sin, exps;
      logic [4:0]  base;
      {w, oldp, sin, expp, exps} = VEC[v];
      base = 5'(24 + 2 * int'(w[5:4]));
      fill_pairs();
      regs[base] = oldp[7:0];
      regs[base + 1] = oldp[15:8];
      sreg_in = sin;
      issue(w, lat);
      check("R4 result", 32'({regs[base + 1], regs[base]}), 32'(expp));
      check("R8 R9 R10 status", 32'(sreg_cap), 32'(exps));
      check("R7 latency", 32'(lat), 32'd3);
      check("R7 single done", 32'(done_n), 32'd1);
      check("R5 write count", 32'(wr_n), 32'd2);
      check("R3 R5 low first", 32'(wr_log[0]), 32'(base));
      check("R3 R5 high second", 32'(wr_log[1]), 32'(base + 1));
      for (int r = 24; r < 32; r++)
        if (r != int'(base) && r != int'(base) + 1)
          check("R5 other regs kept", 32'(regs[r]), 32'h5A);
    end

    // R2: non-matching word taken but has no effect
    fill_pairs();
    @(negedge clk);
    #1;
    wr_n = 0; sw_n = 0; done_n = 0;
    insn_valid = 1'b1; insn = 16'h9701;
    @(negedge clk);
    #1;
    check("R2 ready stays", 32'(insn_ready), 32'd1);
    check("R2 not busy", 32'(busy), 32'd0);
    insn_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R2 no reg write", 32'(wr_n), 32'd0);
    check("R2 no status write", 32'(sw_n), 32'd0);
    check("R2 no done", 32'(done_n), 32'd0);
    check("R2 pair kept", 32'({regs[25], regs[24]}), 32'h5A5A);

    // R6: second request while busy is not taken
    fill_pairs();
    regs[24] = 8'h10; regs[25] = 8'h00;
    sreg_in = 8'h00;
    @(negedge clk);
    #1;
    wr_n = 0; sw_n = 0; done_n = 0;
    insn_valid = 1'b1; insn = 16'h9605;
    @(negedge clk);
    #1;
    check("R6 busy", 32'(busy), 32'd1);
    check("R6 ready low", 32'(insn_ready), 32'd0);
    insn = 16'h9631;
    @(negedge clk);
    #1;
    check("R6 ready low hi", 32'(insn_ready), 32'd0);
    @(negedge clk);
    #1;
    check("R6 busy in done cycle", 32'({busy, done, insn_ready}), 32'b110);
    insn_valid = 1'b0;
    @(negedge clk);
    #1;
    check("R7 done dropped", 32'(done), 32'd0);
    check("R6 ready back", 32'(insn_ready), 32'd1);
    repeat (4) @(negedge clk);
    #1;
    check("R6 one op only", 32'(wr_n), 32'd2);
    check("R6 first op result", 32'({regs[25], regs[24]}), 32'h0015);
    check("R6 second pair kept", 32'({regs[31], regs[30]}), 32'h5A5A);

    // R8: zero result from low byte carry ripple, status bits
    fill_pairs();
    regs[28] = 8'hC1; regs[29] = 8'hFF;
    sreg_in = 8'h00;
    issue(16'h96EF, lat);
    check("R8 zero wrap", 32'({regs[29], regs[28]}), 32'h0000);
    check("R8 R9 Z and C", 32'(sreg_cap), 32'h03);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule